// File: doc/BRIEF.md
# External Interrupt Acceptance Unit

This unit sits between a processor core and an external interrupt controller. The controller presents one request at a time. Each request carries a handler address, a priority level, a target register set and a non-maskable flag. In the cycle the request is valid, the unit compares it with the core's current status word and decides whether to take it. The request inputs are sampled only in that deciding cycle, so the controller is free to change them afterwards.

When the unit takes a request, it does the following at the next clock edge:
- It forms the new status word and publishes it.
- It loads the program counter with the handler address.
- It makes the requested register set the active one.
- It saves the return address and the old status word.

The old status goes to one of two places. For register set 0 it goes to a single saved-status register. For any other set it goes to that set's own slot in a small per-set bank. The core reads the bank through a combinational read port.

Top module: `eirq_accept`

## Requirements
- R1: A request with the non-maskable flag set is taken only when status bit 22 (NMI) is clear. In that case the enable bit and the level are not consulted.
- R2: A maskable request is refused when status bit 0 (PIE) is clear. It is also refused when the requested level is not above the current level field, status bits 9:4.
- R3: A maskable request that passes R2 is taken when its effective set differs from the current set field, status bits 15:10. If the sets are equal, it is taken only when status bit 23 (RSIE) is set.
- R4: A take raises `take` and `ack` for exactly one cycle, in the cycle after the request was sampled. A request presented while `take` is high is refused.
- R5: The new status keeps every bit of the old status except these:
  - bits 15:10 become the effective set;
  - bits 9:4 become the requested level;
  - bit 22 becomes the non-maskable flag;
  - bit 23 and bit 1 (user mode) are cleared;
  - bit 3 (IH) is set.
- R6: When old status bit 2 (EH) is clear, new bits 21:16 (PRS) take the old set field, and the effective set's return-address slot receives `cur_pc + 4`. When EH is set, PRS is unchanged and nothing is saved.
- R7: With EH clear and an effective set of 0, `estatus` receives the old status word.
- R8: With EH clear and a nonzero effective set, that set's saved-status slot receives the old status word. Bit 31 of the saved word is set exactly when the new set differs from the old set field.
- R9: After a take, `new_pc` equals the sampled handler address and `active_set` equals the new set. Both hold until the next take. A refused request changes no output and no stored slot.
- R10: A requested set number at or above `NSETS` is treated as set 0, both for requests and for `rd_set`.
- R11: After reset:
  - `take`, `ack`, `new_status`, `new_pc`, `active_set` and `estatus` are zero;
  - every bank slot reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Controller presents a request this cycle |
| req_handler | input | AW | Requested handler address |
| req_level | input | 6 | Requested interrupt level |
| req_set | input | 6 | Requested register set |
| req_nmi | input | 1 | Non-maskable request flag |
| cur_status | input | 32 | Core's current status word |
| cur_pc | input | AW | Address of the interrupted instruction |
| take | output | 1 | One-cycle pulse: request taken |
| ack | output | 1 | One-cycle acknowledge to the controller |
| new_status | output | 32 | Status word produced by the last take |
| new_pc | output | AW | Program counter after the last take |
| active_set | output | 6 | Register set made active by the last take |
| estatus | output | 32 | Saved status for entries into set 0 |
| rd_set | input | 6 | Bank read index (clamped as in R10) |
| rd_sstatus | output | 32 | Saved-status slot of the indexed set |
| rd_ea | output | AW | Return-address slot of the indexed set |

## Verification
The hardest case to reach is a request that the unit refuses only because it is busy. This is a request that would pass every status check but arrives in the cycle `take` is high. The stimulus holds one acceptable request valid for two consecutive cycles against an unchanged status word. The second sample must then produce no pulse and leave every output and slot as the first take left them.

The same-set case is also covered. It is reached by giving the current status the requested set number, first with RSIE clear and then with RSIE set.

// File: rtl/eirq_pkg.sv
package eirq_pkg;
  localparam int SW      = 6;
  localparam int B_PIE   = 0;
  localparam int B_U     = 1;
  localparam int B_EH    = 2;
  localparam int B_IH    = 3;
  localparam int IL_LO   = 4;
  localparam int CRS_LO  = 10;
  localparam int PRS_LO  = 16;
  localparam int B_NMI   = 22;
  localparam int B_RSIE  = 23;
  localparam int B_SRS   = 31;

  // Map an out-of-range set number onto set 0.
  function automatic logic [SW-1:0] clamp_set(input logic [SW-1:0] s, input int unsigned n);
    return (32'(s) < n) ? s : '0;
  endfunction
endpackage

// File: rtl/eirq_decide.sv
module eirq_decide
  import eirq_pkg::*;
(
  input  logic          req_nmi,
  input  logic [SW-1:0] req_level,
  input  logic [SW-1:0] eff_set,
  input  logic          st_pie,
  input  logic          st_nmi,
  input  logic          st_rsie,
  input  logic [SW-1:0] st_il,
  input  logic [SW-1:0] st_crs,
  output logic          ok
);
  logic lvl_above;
  logic set_ok;

  always_comb begin
    lvl_above = req_level > st_il;
    set_ok    = (eff_set != st_crs) || st_rsie;
    if (req_nmi) ok = !st_nmi;
    else         ok = st_pie && lvl_above && set_ok;
  end
endmodule

// File: rtl/eirq_entry.sv
module eirq_entry
  import eirq_pkg::*;
(
  input  logic [31:0]   old_status,
  input  logic [SW-1:0] req_level,
  input  logic [SW-1:0] eff_set,
  input  logic          req_nmi,
  output logic [31:0]   ent_status,
  output logic [31:0]   save_word
);
  logic [SW-1:0] old_crs;

  always_comb begin
    old_crs    = old_status[CRS_LO +: SW];
    ent_status = old_status;
    ent_status[CRS_LO +: SW] = eff_set;
    ent_status[IL_LO +: SW]  = req_level;
    ent_status[B_NMI]        = req_nmi;
    ent_status[B_RSIE]       = 1'b0;
    ent_status[B_U]          = 1'b0;
    ent_status[B_IH]         = 1'b1;
    if (!old_status[B_EH]) ent_status[PRS_LO +: SW] = old_crs;
    save_word = old_status;
    if (eff_set != '0 && eff_set != old_crs) save_word[B_SRS] = 1'b1;
  end
endmodule

// File: rtl/eirq_setbank.sv
module eirq_setbank
  import eirq_pkg::*;
#(
  parameter int NSETS = 8,
  parameter int AW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [SW-1:0] wr_set,
  input  logic          wr_sst_en,
  input  logic [31:0]   wr_sst,
  input  logic [AW-1:0] wr_ea,
  input  logic [SW-1:0] rd_set,
  output logic [31:0]   rd_sst,
  output logic [AW-1:0] rd_ea
);
  logic [31:0]   sst_a [NSETS];
  logic [AW-1:0] ea_a  [NSETS];

  for (genvar g = 0; g < NSETS; g++) begin : g_slot
    logic hit;
    assign hit = wr_en && (wr_set == SW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sst_a[g] <= '0;
        ea_a[g]  <= '0;
      end else begin
        if (hit)              ea_a[g]  <= wr_ea;
        if (hit && wr_sst_en) sst_a[g] <= wr_sst;
      end
    end
  end

  always_comb begin
    rd_sst = '0;
    rd_ea  = '0;
    for (int i = 0; i < NSETS; i++) begin
      if (rd_set == SW'(i)) begin
        rd_sst = sst_a[i];
        rd_ea  = ea_a[i];
      end
    end
  end
endmodule

// File: rtl/eirq_accept.sv
module eirq_accept
  import eirq_pkg::*;
#(
  parameter int NSETS = 8,
  parameter int AW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] req_handler,
  input  logic [5:0]    req_level,
  input  logic [5:0]    req_set,
  input  logic          req_nmi,
  input  logic [31:0]   cur_status,
  input  logic [AW-1:0] cur_pc,
  output logic          take,
  output logic          ack,
  output logic [31:0]   new_status,
  output logic [AW-1:0] new_pc,
  output logic [5:0]    active_set,
  output logic [31:0]   estatus,
  input  logic [5:0]    rd_set,
  output logic [31:0]   rd_sstatus,
  output logic [AW-1:0] rd_ea
);
  localparam logic [AW-1:0] PC_STEP = AW'(4);

  logic [1:0]    rst_sync_q;
  logic          rst_i_n;
  logic [SW-1:0] eff_set, rd_eff;
  logic          dec_ok, accept, save_en;
  logic [31:0]   ent_status, save_word;

  logic          take_q, take_d;
  logic [31:0]   status_q, status_d;
  logic [AW-1:0] pc_q, pc_d;
  logic [SW-1:0] set_q, set_d;
  logic [31:0]   est_q, est_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  assign eff_set = clamp_set(req_set, NSETS);
  assign rd_eff  = clamp_set(rd_set, NSETS);

  eirq_decide u_decide (
    .req_nmi   (req_nmi),
    .req_level (req_level),
    .eff_set   (eff_set),
    .st_pie    (cur_status[B_PIE]),
    .st_nmi    (cur_status[B_NMI]),
    .st_rsie   (cur_status[B_RSIE]),
    .st_il     (cur_status[IL_LO +: SW]),
    .st_crs    (cur_status[CRS_LO +: SW]),
    .ok        (dec_ok)
  );

  eirq_entry u_entry (
    .old_status (cur_status),
    .req_level  (req_level),
    .eff_set    (eff_set),
    .req_nmi    (req_nmi),
    .ent_status (ent_status),
    .save_word  (save_word)
  );

  assign accept  = req_valid && !take_q && dec_ok;
  assign save_en = accept && !cur_status[B_EH];

  eirq_setbank #(.NSETS(NSETS), .AW(AW)) u_bank (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .wr_en     (save_en),
    .wr_set    (eff_set),
    .wr_sst_en (eff_set != '0),
    .wr_sst    (save_word),
    .wr_ea     (cur_pc + PC_STEP),
    .rd_set    (rd_eff),
    .rd_sst    (rd_sstatus),
    .rd_ea     (rd_ea)
  );

  always_comb begin
    take_d   = accept;
    status_d = accept ? ent_status  : status_q;
    pc_d     = accept ? req_handler : pc_q;
    set_d    = accept ? eff_set     : set_q;
    est_d    = (save_en && eff_set == '0) ? cur_status : est_q;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      take_q   <= 1'b0;
      status_q <= '0;
      pc_q     <= '0;
      set_q    <= '0;
      est_q    <= '0;
    end else begin
      take_q   <= take_d;
      status_q <= status_d;
      pc_q     <= pc_d;
      set_q    <= set_d;
      est_q    <= est_d;
    end
  end

  assign take       = take_q;
  assign ack        = take_q;
  assign new_status = status_q;
  assign new_pc     = pc_q;
  assign active_set = set_q;
  assign estatus    = est_q;
endmodule

// File: rtl/eirq_accept_chk.sv
module eirq_accept_chk #(
  parameter int NSETS = 8,
  parameter int AW    = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_nmi,
  input logic [5:0]    req_level,
  input logic [5:0]    req_set,
  input logic [AW-1:0] req_handler,
  input logic          st_pie,
  input logic          st_nmi,
  input logic          st_rsie,
  input logic [5:0]    st_il,
  input logic [5:0]    st_crs,
  input logic          take,
  input logic          ns_ih,
  input logic          ns_rsie,
  input logic          ns_u,
  input logic [AW-1:0] new_pc
);
  AST_NMI_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !take && req_nmi && st_nmi) |=> !take); // R1
  AST_PIE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_nmi && !st_pie) |=> !take); // R2
  AST_LEVEL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_nmi && req_level <= st_il) |=> !take); // R2
  AST_SAME_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_nmi && 32'(req_set) < 32'(NSETS) && req_set == st_crs && !st_rsie) |=> !take); // R3
  AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !take); // R4
  AST_ENTRY_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (ns_ih && !ns_rsie && !ns_u)); // R5
  AST_HANDLER: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (new_pc == $past(req_handler))); // R9
endmodule

bind eirq_accept eirq_accept_chk #(.NSETS(NSETS), .AW(AW)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_nmi     (req_nmi),
  .req_level   (req_level),
  .req_set     (req_set),
  .req_handler (req_handler),
  .st_pie      (cur_status[0]),
  .st_nmi      (cur_status[22]),
  .st_rsie     (cur_status[23]),
  .st_il       (cur_status[9:4]),
  .st_crs      (cur_status[15:10]),
  .take        (take),
  .ns_ih       (new_status[3]),
  .ns_rsie     (new_status[23]),
  .ns_u        (new_status[1]),
  .new_pc      (new_pc)
);

// File: tb/eirq_accept_tb_top.sv
module eirq_accept_tb_top;
  localparam int NS = 8;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_handler = '0;
  logic [5:0]    req_level = '0;
  logic [5:0]    req_set = '0;
  logic          req_nmi = 1'b0;
  logic [31:0]   cur_status = '0;
  logic [AW-1:0] cur_pc = '0;
  logic [5:0]    rd_set = '0;
  logic          take, ack;
  logic [31:0]   new_status, estatus, rd_sstatus;
  logic [AW-1:0] new_pc, rd_ea;
  logic [5:0]    active_set;

  always #2 clk = ~clk;

  eirq_accept #(.NSETS(NS), .AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_handler(req_handler),
    .req_level(req_level), .req_set(req_set), .req_nmi(req_nmi),
    .cur_status(cur_status), .cur_pc(cur_pc), .take(take), .ack(ack),
    .new_status(new_status), .new_pc(new_pc), .active_set(active_set),
    .estatus(estatus), .rd_set(rd_set), .rd_sstatus(rd_sstatus), .rd_ea(rd_ea)
  );

  typedef struct {
    logic          tk;
    logic [31:0]   st;
    logic [AW-1:0] pc;
    logic [5:0]    set;
    logic [31:0]   est;
    logic [31:0]   sst;
    logic [AW-1:0] ea;
  } exp_t;

  exp_t  expq[$];
  string tagq[$];
  int    n_chk = 0;
  int    n_bad = 0;
  bit    done = 1'b0;

  // Model state held between takes.
  logic [31:0]   m_st = '0, m_est = '0;
  logic [AW-1:0] m_pc = '0;
  logic [5:0]    m_set = '0;
  logic [31:0]   m_sst [NS];
  logic [AW-1:0] m_ea  [NS];

  task automatic check(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Driver: presents one request for 'hold' cycles and queues the expected result.
  task automatic apply(input string tag, input logic [AW-1:0] h, input logic [5:0] lvl,
                       input logic [5:0] set, input logic nmi, input logic [31:0] st,
                       input logic [AW-1:0] pc, input int hold);
    logic busy = 1'b0;
    for (int c = 0; c < hold; c++) begin
      logic [5:0]  eff, crs;
      logic        acc;
      logic [31:0] ns, sv;
      exp_t        e;
      @(negedge clk);
      req_valid = 1'b1; req_handler = h; req_level = lvl; req_set = set;
      req_nmi = nmi; cur_status = st; cur_pc = pc;
      eff = (int'(set) < NS) ? set : 6'd0;   // R10
      rd_set = set;
      crs = st[15:10];
      if (busy)     acc = 1'b0;                // R4
      else if (nmi) acc = !st[22];             // R1
      else          acc = st[0] && (lvl > st[9:4]) && ((eff != crs) || st[23]); // R2 R3
      if (acc) begin
        ns = st;
        ns[15:10] = eff; ns[9:4] = lvl; ns[22] = nmi;
        ns[23] = 1'b0; ns[1] = 1'b0; ns[3] = 1'b1;  // R5
        if (!st[2]) begin                            // R6
          ns[21:16] = crs;
          m_ea[eff] = pc + 4;
          if (eff == 0) m_est = st;                  // R7
          else begin                                 // R8
            sv = st;
            if (eff != crs) sv[31] = 1'b1;
            m_sst[eff] = sv;
          end
        end
        m_st = ns; m_pc = h; m_set = eff;            // R9
      end
      e.tk = acc; e.st = m_st; e.pc = m_pc; e.set = m_set; e.est = m_est;
      e.sst = m_sst[eff]; e.ea = m_ea[eff];
      expq.push_back(e);
      tagq.push_back(tag);
      busy = acc;
    end
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
  endtask

  // Monitor: compares one queued item per edge, just after the edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expq.size() > 0) begin
        exp_t  e;
        string t;
        e = expq.pop_front();
        t = tagq.pop_front();
        check(t, "take", 64'(take), 64'(e.tk));
        check(t, "ack", 64'(ack), 64'(e.tk));
        check(t, "new_status", 64'(new_status), 64'(e.st));
        check(t, "new_pc", 64'(new_pc), 64'(e.pc));
        check(t, "active_set", 64'(active_set), 64'(e.set));
        check(t, "estatus", 64'(estatus), 64'(e.est));
        check(t, "rd_sstatus", 64'(rd_sstatus), 64'(e.sst));
        check(t, "rd_ea", 64'(rd_ea), 64'(e.ea));
      end
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NS; i++) begin m_sst[i] = '0; m_ea[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R11: reset state
    for (int i = 0; i < NS; i++) begin
      rd_set = 6'(i);
      #1;
      check("R11", "slot sstatus", 64'(rd_sstatus), 64'd0);
      check("R11", "slot ea", 64'(rd_ea), 64'd0);
    end
    check("R11", "take", 64'(take), 64'd0);
    check("R11", "ack", 64'(ack), 64'd0);
    check("R11", "new_status", 64'(new_status), 64'd0);
    check("R11", "new_pc", 64'(new_pc), 64'd0);
    check("R11", "active_set", 64'(active_set), 64'd0);
    check("R11", "estatus", 64'(estatus), 64'd0);

    // R3 R5 R6 R8 R9: different set, EH clear, user bit set in old status
    apply("R3_R8", 32'h0000_1000, 6'd5, 6'd2, 1'b0, 32'h0000_0023, 32'h0000_0400, 1);
    // R2: enable clear
    apply("R2_pie", 32'h0000_2000, 6'd5, 6'd3, 1'b0, 32'h0000_0020, 32'h0000_0500, 1);
    // R2: level equal and below current
    apply("R2_eq", 32'h0000_2100, 6'd2, 6'd3, 1'b0, 32'h0000_0021, 32'h0000_0504, 1);
    apply("R2_lo", 32'h0000_2200, 6'd1, 6'd3, 1'b0, 32'h0000_0021, 32'h0000_0508, 1);
    // R3: same set without and with RSIE
    apply("R3_norsie", 32'h0000_3000, 6'd4, 6'd3, 1'b0, 32'h0000_0C23, 32'h0000_0600, 1);
    apply("R3_rsie", 32'h0000_3100, 6'd4, 6'd3, 1'b0, 32'h0080_0C23, 32'h0000_0604, 1);
    // R1: non-maskable with enable clear and level zero; then masked by NMI bit
    apply("R1_take", 32'h0000_4000, 6'd0, 6'd1, 1'b1, 32'h0000_00F0, 32'h0000_0700, 1);
    apply("R1_mask", 32'h0000_4100, 6'd9, 6'd4, 1'b1, 32'h0040_0001, 32'h0000_0704, 1);
    // R7: into set 0 from set 4
    apply("R7", 32'h0000_5000, 6'd7, 6'd0, 1'b0, 32'h0000_1021, 32'h0000_0800, 1);
    // R6: EH set, no saves and PRS unchanged
    apply("R6_eh", 32'h0000_6000, 6'd3, 6'd6, 1'b0, 32'h0005_0405, 32'h0000_0900, 1);
    // R10: out-of-range set behaves as set 0
    apply("R10", 32'h0000_7000, 6'd9, 6'd12, 1'b0, 32'h0000_0821, 32'h0000_0A00, 1);
    // R4: request held for two cycles, second sample refused while busy
    apply("R4", 32'h0000_8000, 6'd4, 6'd5, 1'b0, 32'h0000_0021, 32'h0000_0B00, 2);
    // R9: later take overwrites handler and set
    apply("R9", 32'h0000_9000, 6'd6, 6'd7, 1'b0, 32'h0000_1421, 32'h0000_0C00, 1);

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule